// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block arbitrates six interrupt sources for a small controller core. Two sources are external pins. A request from a pin is recorded when the pin falls from high to low. The other four sources are single-cycle pulses: timer 0 overflow, timer 1 overflow, a time-base tick and a real-time-clock tick. Each source has a request flag and an enable bit. These bits, together with a global enable, sit in two 8-bit control registers that software can read and write.

Once per instruction cycle the core raises `smp_phase`. On that cycle the block grants the highest-priority source that is both pending and enabled. It does so only if the global enable is set and the core reports that its return stack still has room. A grant does three things: it pulses `irq_take`, it presents the source's vector, and it clears both that source's flag and the global enable. When the core executes a return-from-interrupt it pulses `reti`, which sets the global enable again. While the stack is full, no grant is made, but requests keep being recorded. They are served once the stack has room again.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After a synchronous reset, every enable, every request flag and the global enable are 0, both control registers read 0x00 and `irq_take` is 0.
- R2: Control register 0 (`reg_sel`=0) maps bit0 to the global enable, bits 1..3 to the enables of ext0, ext1 and timer0, and bits 4..6 to the flags of ext0, ext1 and timer0. Bit 7 reads 0. A write of 0x7F reads back as 0x7F.
- R3: Control register 1 (`reg_sel`=1) maps bits 0..2 to the enables of timer1, time base and RTC, and bits 4..6 to their flags. Bits 3 and 7 read 0, so a write of 0x7F reads back as 0x77.
- R4: A high-to-low transition on `ext_pin[i]` sets the flag of external source i no later than three clocks later (two synchroniser stages, then edge detection). A low-to-high transition sets nothing.
- R5: A one-cycle pulse on `tmr_ovf[0]`, `tmr_ovf[1]`, `tbase_tick` or `rtc_tick` sets the flag of timer0, timer1, time base or RTC respectively, whether or not that source is enabled.
- R6: The priority from highest to lowest is ext0, ext1, timer0, timer1, time base, RTC. Their vectors are 0x04, 0x08, 0x0C, 0x10, 0x14 and 0x18.
- R7: A grant is made only on a clock where `smp_phase` is 1, the global enable is 1 and some source has both its flag and its enable set. A flag whose enable is 0 stays set and is never granted.
- R8: On a grant, `irq_take` is 1 for exactly one cycle after the sampling edge, and `irq_vector` holds the vector. The granted flag and the global enable both read 0 from that cycle on.
- R9: While `stack_full` is 1, no grant is made, but flags continue to be set by events. The pending request is granted on the first sampling cycle after `stack_full` drops.
- R10: A flag stays set until it is granted or cleared by a software write. With the global enable cleared, nothing is granted until a `reti` pulse sets the global enable again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_pin | input | 2 | External request pins, asynchronous, idle high |
| tmr_ovf | input | 2 | Timer 1 and timer 0 overflow pulses |
| tbase_tick | input | 1 | Time-base tick pulse |
| rtc_tick | input | 1 | Real-time-clock tick pulse |
| smp_phase | input | 1 | High on the one clock per instruction cycle on which requests are sampled |
| stack_full | input | 1 | Return stack of the core is full |
| reti | input | 1 | Return-from-interrupt pulse; sets the global enable |
| reg_wr | input | 1 | Write strobe for the control registers |
| reg_sel | input | 1 | Selects control register 0 or 1 for writing |
| reg_wdata | input | 7 | Write data for bits 6..0 (bit 7 has no storage) |
| ctl0_rdata | output | 8 | Read value of control register 0 |
| ctl1_rdata | output | 8 | Read value of control register 1 |
| irq_take | output | 1 | One-cycle grant pulse |
| irq_vector | output | 8 | Vector of the most recent grant |

## Verification
The bench builds the block with its default parameters: two synchroniser stages, a vector base of 0x04 and a step of 4. With these values the vector values stated in R6 are exactly what appears on `irq_vector`. The fixed synchroniser depth keeps the pin-to-flag latency short and known, so the bench can check an edge on a pin within a few clocks. Pending all six sources at once and granting repeatedly with `reti` in between walks the whole priority chain in one scenario.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int N_SRC = 6;
    localparam int IDX_W = $clog2(N_SRC);

    typedef enum logic [IDX_W-1:0] {
        SRC_EXT0  = 3'd0,
        SRC_EXT1  = 3'd1,
        SRC_TMR0  = 3'd2,
        SRC_TMR1  = 3'd3,
        SRC_TBASE = 3'd4,
        SRC_RTC   = 3'd5
    } src_e;

    typedef struct packed {
        logic             gie;
        logic [N_SRC-1:0] en;
        logic [N_SRC-1:0] flag;
    } ictl_t;

    function automatic logic [7:0] pack_ctl0(input ictl_t s);
        return {1'b0, s.flag[2:0], s.en[2:0], s.gie};
    endfunction

    function automatic logic [7:0] pack_ctl1(input ictl_t s);
        return {1'b0, s.flag[5:3], 1'b0, s.en[5:3]};
    endfunction

    function automatic ictl_t apply_write(input ictl_t s, input logic sel,
                                          input logic [6:0] wd);
        ictl_t r;
        r = s;
        if (!sel) begin
            r.gie       = wd[0];
            r.en[2:0]   = wd[3:1];
            r.flag[2:0] = wd[6:4];
        end else begin
            r.en[5:3]   = wd[2:0];
            r.flag[5:3] = wd[6:4];
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
    parameter int   STAGES = 2,
    parameter logic IDLE   = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic fall
);
    logic [STAGES-1:0] shr;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shr    <= {STAGES{IDLE}};
            prev_q <= IDLE;
        end else begin
            shr    <= {shr[STAGES-2:0], pin};
            prev_q <= shr[STAGES-1];
        end
    end

    assign fall = prev_q & ~shr[STAGES-1];

    // R4
    single_fall_chk: assert property (@(posedge clk) disable iff (rst)
        fall |=> !fall);

endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
    parameter int N = 6,
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    output logic [N-1:0] pick,
    output logic [W-1:0] idx,
    output logic         any
);
    logic [N:0] seen;

    assign seen[0] = 1'b0;

    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_chain
            assign pick[i]   = req[i] & ~seen[i];
            assign seen[i+1] = seen[i] | req[i];
        end
    endgenerate

    assign any = seen[N];

    always_comb begin
        idx = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (req[k]) idx = W'(k);
        end
    end

    // R6
    one_pick_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pick));

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int VEC_W       = 8,
    parameter int VEC_BASE    = 4,
    parameter int VEC_STEP    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       ext_pin,
    input  logic [1:0]       tmr_ovf,
    input  logic             tbase_tick,
    input  logic             rtc_tick,
    input  logic             smp_phase,
    input  logic             stack_full,
    input  logic             reti,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [6:0]       reg_wdata,
    output logic [7:0]       ctl0_rdata,
    output logic [7:0]       ctl1_rdata,
    output logic             irq_take,
    output logic [VEC_W-1:0] irq_vector
);
    localparam int N_EXT = 2;

    ictl_t            st_q, st_n;
    logic [N_EXT-1:0] ext_fall;
    logic [N_SRC-1:0] events;
    logic [N_SRC-1:0] pend;
    logic [N_SRC-1:0] pick;
    logic [IDX_W-1:0] pick_idx;
    logic             pick_any;
    logic             take;
    logic             take_q;
    logic [VEC_W-1:0] vec_q;

    genvar p;
    generate
        for (p = 0; p < N_EXT; p++) begin : g_pin
            irq_pin_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync (
                .clk  (clk),
                .rst  (rst),
                .pin  (ext_pin[p]),
                .fall (ext_fall[p])
            );
        end
    endgenerate

    assign events = {rtc_tick, tbase_tick, tmr_ovf[1], tmr_ovf[0], ext_fall};
    assign pend   = st_q.flag & st_q.en;

    irq_prio_arb #(.N(N_SRC), .W(IDX_W)) u_arb (
        .clk  (clk),
        .rst  (rst),
        .req  (pend),
        .pick (pick),
        .idx  (pick_idx),
        .any  (pick_any)
    );

    assign take = smp_phase & st_q.gie & ~stack_full & pick_any;

    always_comb begin
        st_n = st_q;
        if (reg_wr) st_n = apply_write(st_n, reg_sel, reg_wdata);
        if (reti)   st_n.gie = 1'b1;
        if (take) begin
            st_n.flag = st_n.flag & ~pick;
            st_n.gie  = 1'b0;
        end
        st_n.flag = st_n.flag | events;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= '0;
            take_q <= 1'b0;
            vec_q  <= '0;
        end else begin
            st_q   <= st_n;
            take_q <= take;
            if (take) vec_q <= VEC_W'(VEC_BASE + VEC_STEP * int'(pick_idx));
        end
    end

    assign ctl0_rdata = pack_ctl0(st_q);
    assign ctl1_rdata = pack_ctl1(st_q);
    assign irq_take   = take_q;
    assign irq_vector = vec_q;

    // R9
    no_grant_full_chk: assert property (@(posedge clk) disable iff (rst)
        irq_take |-> !$past(stack_full));

    // R7
    grant_cond_chk: assert property (@(posedge clk) disable iff (rst)
        irq_take |-> ($past(smp_phase) && $past(st_q.gie)));

    // R8
    gie_drop_chk: assert property (@(posedge clk) disable iff (rst)
        irq_take |-> !st_q.gie);

    // R8
    take_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        irq_take |=> !irq_take);

endmodule

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] ext_pin;
    logic [1:0] tmr_ovf;
    logic       tbase_tick, rtc_tick, smp_phase, stack_full, reti;
    logic       reg_wr, reg_sel;
    logic [6:0] reg_wdata;
    logic [7:0] ctl0_rdata, ctl1_rdata;
    logic       irq_take;
    logic [7:0] irq_vector;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    irq_vector_ctrl u_irq_vector_ctrl (
        .clk(clk), .rst(rst), .ext_pin(ext_pin), .tmr_ovf(tmr_ovf),
        .tbase_tick(tbase_tick), .rtc_tick(rtc_tick), .smp_phase(smp_phase),
        .stack_full(stack_full), .reti(reti), .reg_wr(reg_wr),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .ctl0_rdata(ctl0_rdata),
        .ctl1_rdata(ctl1_rdata), .irq_take(irq_take), .irq_vector(irq_vector)
    );

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [6:0] d);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic sample();
        smp_phase = 1'b1;
        step();
        smp_phase = 1'b0;
    endtask

    task automatic t_reset();
        // R1
        chk(ctl0_rdata == 8'h00, "R1 ctl0", ctl0_rdata, 8'h00);
        chk(ctl1_rdata == 8'h00, "R1 ctl1", ctl1_rdata, 8'h00);
        chk(irq_take == 1'b0, "R1 take", irq_take, 0);
    endtask

    task automatic t_regs();
        wr(1'b0, 7'h7F);
        chk(ctl0_rdata == 8'h7F, "R2 ctl0 readback", ctl0_rdata, 8'h7F);
        wr(1'b1, 7'h7F);
        chk(ctl1_rdata == 8'h77, "R3 ctl1 readback", ctl1_rdata, 8'h77);
        wr(1'b0, 7'h00);
        wr(1'b1, 7'h00);
        chk(ctl0_rdata == 8'h00 && ctl1_rdata == 8'h00, "R2 clear",
            {ctl1_rdata, ctl0_rdata}, 0);
    endtask

    task automatic t_ext();
        ext_pin[1] = 1'b0;
        step(4);
        chk(ctl0_rdata == 8'h20, "R4 ext1 fall", ctl0_rdata, 8'h20);
        wr(1'b0, 7'h00);
        ext_pin[1] = 1'b1;
        step(4);
        chk(ctl0_rdata == 8'h00, "R4 rise ignored", ctl0_rdata, 8'h00);
        ext_pin[0] = 1'b0;
        step(3);
        chk(ctl0_rdata == 8'h10, "R4 ext0 fall", ctl0_rdata, 8'h10);
        ext_pin[0] = 1'b1;
        wr(1'b0, 7'h00);
        step(3);
    endtask

    task automatic t_internal();
        tmr_ovf[0] = 1'b1; step(); tmr_ovf[0] = 1'b0;
        chk(ctl0_rdata == 8'h40, "R5 tmr0 flag", ctl0_rdata, 8'h40);
        tmr_ovf[1] = 1'b1; step(); tmr_ovf[1] = 1'b0;
        chk(ctl1_rdata == 8'h10, "R5 tmr1 flag", ctl1_rdata, 8'h10);
        tbase_tick = 1'b1; step(); tbase_tick = 1'b0;
        chk(ctl1_rdata == 8'h30, "R5 tbase flag", ctl1_rdata, 8'h30);
        rtc_tick = 1'b1; step(); rtc_tick = 1'b0;
        chk(ctl1_rdata == 8'h70, "R5 rtc flag", ctl1_rdata, 8'h70);
        wr(1'b0, 7'h00);
        wr(1'b1, 7'h00);
    endtask

    task automatic t_prio();
        logic [7:0] e0, e1;
        wr(1'b0, 7'h7F);
        wr(1'b1, 7'h7F);
        for (int i = 0; i < 6; i++) begin
            sample();
            chk(irq_take == 1'b1, "R6 take", irq_take, 1);
            chk(irq_vector == 8'(4 + 4 * i), "R6 vector", irq_vector, 4 + 4 * i);
            e0 = 8'h0E;
            e1 = 8'h07;
            for (int j = i + 1; j < 6; j++) begin
                if (j < 3) e0[4 + j] = 1'b1;
                else       e1[1 + j] = 1'b1;
            end
            chk(ctl0_rdata == e0, "R8 ctl0 after grant", ctl0_rdata, e0);
            chk(ctl1_rdata == e1, "R8 ctl1 after grant", ctl1_rdata, e1);
            step();
            chk(irq_take == 1'b0, "R8 single pulse", irq_take, 0);
            reti = 1'b1; step(); reti = 1'b0;
            chk(ctl0_rdata[0] == 1'b1, "R10 reti sets gie", ctl0_rdata[0], 1);
        end
        wr(1'b0, 7'h00);
        wr(1'b1, 7'h00);
    endtask

    task automatic t_gate();
        wr(1'b0, 7'h11);
        sample();
        chk(irq_take == 1'b0, "R7 disabled no take", irq_take, 0);
        chk(ctl0_rdata == 8'h11, "R7 flag kept", ctl0_rdata, 8'h11);
        wr(1'b0, 7'h13);
        step(3);
        chk(irq_take == 1'b0, "R7 no phase no take", irq_take, 0);
        sample();
        chk(irq_take == 1'b1 && irq_vector == 8'h04, "R7 take on phase",
            {irq_take, irq_vector}, 9'h104);
        chk(ctl0_rdata == 8'h02, "R8 flag and gie cleared", ctl0_rdata, 8'h02);
    endtask

    task automatic t_stack();
        wr(1'b0, 7'h13);
        stack_full = 1'b1;
        sample();
        chk(irq_take == 1'b0, "R9 full blocks", irq_take, 0);
        tmr_ovf[0] = 1'b1; step(); tmr_ovf[0] = 1'b0;
        sample();
        chk(irq_take == 1'b0, "R9 still blocked", irq_take, 0);
        chk(ctl0_rdata == 8'h53, "R9 flags recorded", ctl0_rdata, 8'h53);
        stack_full = 1'b0;
        sample();
        chk(irq_take == 1'b1 && irq_vector == 8'h04, "R9 granted after room",
            {irq_take, irq_vector}, 9'h104);
        chk(ctl0_rdata == 8'h42, "R9 ctl0 after grant", ctl0_rdata, 8'h42);
    endtask

    task automatic t_reti();
        wr(1'b0, 7'h48);
        sample();
        chk(irq_take == 1'b0, "R10 no gie no take", irq_take, 0);
        chk(ctl0_rdata == 8'h48, "R10 flag held", ctl0_rdata, 8'h48);
        reti = 1'b1; step(); reti = 1'b0;
        chk(ctl0_rdata == 8'h49, "R10 reti gie", ctl0_rdata, 8'h49);
        sample();
        chk(irq_take == 1'b1 && irq_vector == 8'h0C, "R10 take tmr0",
            {irq_take, irq_vector}, 9'h10C);
        chk(ctl0_rdata == 8'h08, "R10 ctl0 after", ctl0_rdata, 8'h08);
    endtask

    initial begin
        rst = 1'b1; ext_pin = 2'b11; tmr_ovf = 2'b00; tbase_tick = 1'b0;
        rtc_tick = 1'b0; smp_phase = 1'b0; stack_full = 1'b0; reti = 1'b0;
        reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
        step(3);
        rst = 1'b0;
        step();
        t_reset();
        t_regs();
        t_ext();
        t_internal();
        t_prio();
        t_gate();
        t_stack();
        t_reti();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule